// File: doc/BRIEF.md
# Four-Pixel Region Trigger-Latency Hit Store

This block is the digital logic shared by a 2x2 group of pixels. Each pixel supplies a discriminator level; the block measures how many clocks each pulse stays high (its time-over-threshold, ToT) and keeps the result inside the region. It does not forward every hit. Each hit event waits in a slot for a programmable trigger latency, and a trigger leaves the region only the hits it confirms, one word per pixel, each tagged with its pixel address.

The block has five slots. Each slot has its own latency counter, and each pixel has a ToT store per slot. A rising discriminator edge on any pixel opens a hit event. The event takes the lowest-numbered free slot. Every pixel that rose on that same clock edge is recorded in that slot. Confirmed slots are drained over a valid/ready stream. A word offered with valid high stays unchanged until ready is seen high on a clock edge. A slot only becomes free again after its last word has been accepted. If no slot is free, the hit is dropped and a sticky overflow flag is raised.

Top module: `pixreg_latbuf`

## Requirements
- R1: A hit event starts on a clock edge at which at least one discriminator input is high and was low at the previous edge. All pixels rising on that edge belong to the event. A pixel whose input was already high does not join it.
- R2: A new event is captured with latency setting L. The event is confirmed only if `trig_i` is high at the edge exactly L+1 edges after the capture edge. If the trigger is early, late or absent, the event is discarded and produces no word.
- R3: The ToT reported for a pixel is the number of edges, starting with the capture edge, at which its discriminator was high. It saturates at 15.
- R4: If a pixel's discriminator is still high at the confirming edge (capture edge + L + 1), its ToT is reported as 15.
- R5: A confirmed event yields exactly one word per pixel in the event. `word_addr_o` carries the pixel index (0 to 3, the bit position in `disc_i`), and lower indices come first. When several slots are confirmed, the lowest-numbered slot is drained first.
- R6: While `word_valid_o` is high and `word_ready_i` is low, the address and ToT stay stable. A word is consumed on an edge where both are high, and the next word (if any) appears after that edge.
- R7: Five slots track events independently. An event that starts while all five are occupied is dropped with no word, and `ovf_o` rises after that edge. `ovf_o` stays high until an edge where `ovf_clr_i` is high (a drop on the same edge wins).
- R8: An active-low `rst_n` empties every slot, drops pending words and clears `ovf_o`.
- R9: Overlapping events keep separate latency windows: a trigger confirms only the event whose window ends on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Region clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | NPIX (4) | Discriminator level per pixel |
| trig_i | input | 1 | Trigger strobe, sampled at each edge |
| lat_cfg_i | input | LATW (8) | Latency setting L, loaded when an event is captured |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky overflow: an event was dropped |
| word_valid_o | output | 1 | Stream valid |
| word_ready_i | input | 1 | Stream ready from the periphery |
| word_addr_o | output | AW (2) | Pixel index of the current word |
| word_tot_o | output | TOTW (4) | ToT of the current word |

## Verification
The bench works the edges of the trigger window: a trigger one clock early or late must produce nothing, and a design with an off-by-one in the counter would either emit those words or lose the correctly timed ones. It probes ToT at 14, 15 and beyond, and a pulse that is still high exactly at the confirming edge for latencies 0, 3 and 20. A wrong saturation rule shows up there as wrapped or truncated values. It overlaps two events so that only the later one is triggered, fills all five slots to force a drop and clear the sticky flag, and holds ready low so that a design which lets the word drift or frees the slot early is caught. A reset issued while a word is pending must make that word disappear.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_READ = 2'd2
  } slot_st_e;
endpackage

// File: rtl/pixreg_prio.sv
// Lowest-index request picker.
module pixreg_prio #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pixreg_slot.sv
// One event slot: latency countdown, trigger decision, pending-pixel mask.
module pixreg_slot
  import pixreg_pkg::*;
#(
  parameter int NPIX = 4,
  parameter int LATW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            claim_i,
  input  logic [NPIX-1:0] mask_i,
  input  logic [LATW-1:0] lat_i,
  input  logic            trig_i,
  input  logic            pop_i,
  input  logic [NPIX-1:0] pop_pix_i,
  output slot_st_e        state_o,
  output logic [NPIX-1:0] mask_o,
  output logic            expire_o
);
  logic [LATW-1:0] cnt_q;
  logic [NPIX-1:0] left;

  assign expire_o = (state_o == SLOT_WAIT) && (cnt_q == '0);
  assign left     = mask_o & ~pop_pix_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= SLOT_FREE;
      cnt_q   <= '0;
      mask_o  <= '0;
    end else begin
      unique case (state_o)
        SLOT_FREE: if (claim_i) begin
          state_o <= SLOT_WAIT;
          cnt_q   <= lat_i;
          mask_o  <= mask_i;
        end
        SLOT_WAIT: if (cnt_q != '0) begin
          cnt_q <= cnt_q - LATW'(1);
        end else if (trig_i) begin
          state_o <= SLOT_READ;
        end else begin
          state_o <= SLOT_FREE;
          mask_o  <= '0;
        end
        SLOT_READ: if (pop_i) begin
          mask_o <= left;
          if (left == '0) state_o <= SLOT_FREE;
        end
        default: state_o <= SLOT_FREE;
      endcase
    end
  end
endmodule

// File: rtl/pixreg_pixel.sv
// Per-pixel edge detection and ToT measurement into one store per slot.
module pixreg_pixel #(
  parameter int NSLOT = 5,
  parameter int TOTW  = 4,
  parameter int SW    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disc_i,
  input  logic                       claim_ok_i,
  input  logic [SW-1:0]              claim_idx_i,
  input  logic [NSLOT-1:0]           expire_i,
  output logic                       rise_o,
  output logic [NSLOT-1:0][TOTW-1:0] tot_o
);
  localparam logic [TOTW-1:0] TOT_MAX = {TOTW{1'b1}};

  logic          disc_q;
  logic          act_q;
  logic [SW-1:0] slot_q;

  assign rise_o = disc_i & ~disc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disc_q <= 1'b0;
      act_q  <= 1'b0;
      slot_q <= '0;
      tot_o  <= '0;
    end else begin
      disc_q <= disc_i;
      if (rise_o && claim_ok_i) begin
        act_q              <= 1'b1;
        slot_q             <= claim_idx_i;
        tot_o[claim_idx_i] <= TOTW'(1);
      end else if (act_q) begin
        if (expire_i[slot_q]) begin
          act_q <= 1'b0;
          if (disc_i) tot_o[slot_q] <= TOT_MAX;
        end else if (disc_i) begin
          if (tot_o[slot_q] != TOT_MAX) tot_o[slot_q] <= tot_o[slot_q] + TOTW'(1);
        end else begin
          act_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pixreg_latbuf.sv
module pixreg_latbuf
  import pixreg_pkg::*;
#(
  parameter int NPIX  = 4,
  parameter int NSLOT = 5,
  parameter int TOTW  = 4,
  parameter int LATW  = 8,
  parameter int AW    = $clog2(NPIX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] disc_i,
  input  logic            trig_i,
  input  logic [LATW-1:0] lat_cfg_i,
  input  logic            ovf_clr_i,
  output logic            ovf_o,
  output logic            word_valid_o,
  input  logic            word_ready_i,
  output logic [AW-1:0]   word_addr_o,
  output logic [TOTW-1:0] word_tot_o
);
  localparam int SW = $clog2(NSLOT);

  logic [NPIX-1:0]                       rise;
  logic [NPIX-1:0][NSLOT-1:0][TOTW-1:0]  tot_all;
  slot_st_e                              st [NSLOT];
  logic [NSLOT-1:0][NPIX-1:0]            smask;
  logic [NSLOT-1:0]                      sfree, sread, sexp, claim_vec, pop_vec;
  logic                                  any_free, any_rise, claim_ok, rd_any, pix_any, pop;
  logic [SW-1:0]                         free_idx, rd_idx, sel, sel_q;
  logic                                  lock_q;
  logic [NPIX-1:0]                       cur_mask, pop_pix;
  logic [AW-1:0]                         pix_idx;

  pixreg_prio #(.N(NSLOT), .IW(SW)) u_free (.req(sfree), .any(any_free), .idx(free_idx));

  assign any_rise  = |rise;
  assign claim_ok  = any_rise & any_free;
  assign claim_vec = claim_ok ? (NSLOT'(1) << free_idx) : '0;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    pixreg_pixel #(.NSLOT(NSLOT), .TOTW(TOTW), .SW(SW)) u_pix (
      .clk(clk), .rst_n(rst_n), .disc_i(disc_i[p]), .claim_ok_i(claim_ok),
      .claim_idx_i(free_idx), .expire_i(sexp), .rise_o(rise[p]), .tot_o(tot_all[p])
    );
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    pixreg_slot #(.NPIX(NPIX), .LATW(LATW)) u_slot (
      .clk(clk), .rst_n(rst_n), .claim_i(claim_vec[s]), .mask_i(rise),
      .lat_i(lat_cfg_i), .trig_i(trig_i), .pop_i(pop_vec[s]), .pop_pix_i(pop_pix),
      .state_o(st[s]), .mask_o(smask[s]), .expire_o(sexp[s])
    );
    assign sfree[s] = (st[s] == SLOT_FREE);
    assign sread[s] = (st[s] == SLOT_READ);
  end

  // Readout: lowest confirmed slot, locked while a word is stalled.
  pixreg_prio #(.N(NSLOT), .IW(SW)) u_rd (.req(sread), .any(rd_any), .idx(rd_idx));
  assign sel      = lock_q ? sel_q : rd_idx;
  assign cur_mask = smask[sel];
  pixreg_prio #(.N(NPIX), .IW(AW)) u_pick (.req(cur_mask), .any(pix_any), .idx(pix_idx));

  assign word_valid_o = rd_any & pix_any;
  assign word_addr_o  = pix_idx;
  assign word_tot_o   = tot_all[pix_idx][sel];
  assign pop          = word_valid_o & word_ready_i;
  assign pop_vec      = pop ? (NSLOT'(1) << sel) : '0;
  assign pop_pix      = NPIX'(1) << pix_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      lock_q <= word_valid_o & ~word_ready_i;
      sel_q  <= sel;
      if (any_rise && !any_free) ovf_o <= 1'b1;
      else if (ovf_clr_i)        ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pixreg_latbuf_chk.sv
module pixreg_latbuf_chk #(
  parameter int NPIX = 4,
  parameter int TOTW = 4,
  parameter int AW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIX-1:0] disc_i,
  input logic            trig_i,
  input logic            ovf_clr_i,
  input logic            ovf_o,
  input logic            word_valid_o,
  input logic            word_ready_i,
  input logic [AW-1:0]   word_addr_o,
  input logic [TOTW-1:0] word_tot_o
);
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_addr_o) && $stable(word_tot_o)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(disc_i != '0)); // R7
  AST_CONFIRM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid_o) |-> $past(trig_i)); // R2
  AST_TOT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> word_tot_o != '0); // R3
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !word_valid_o && !ovf_o); // R8
endmodule

bind pixreg_latbuf pixreg_latbuf_chk #(.NPIX(NPIX), .TOTW(TOTW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disc_i(disc_i), .trig_i(trig_i), .ovf_clr_i(ovf_clr_i),
  .ovf_o(ovf_o), .word_valid_o(word_valid_o), .word_ready_i(word_ready_i),
  .word_addr_o(word_addr_o), .word_tot_o(word_tot_o)
);

// File: tb/test_pixreg_latbuf.sv
module test_pixreg_latbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] disc_i = '0;
  logic       trig_i = 1'b0;
  logic [7:0] lat_cfg_i = 8'd20;
  logic       ovf_clr_i = 1'b0;
  logic       ovf_o, word_valid_o;
  logic       word_ready_i = 1'b1;
  logic [1:0] word_addr_o;
  logic [3:0] word_tot_o;
  int         errors = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  pixreg_latbuf i_pixreg_latbuf (
    .clk(clk), .rst_n(rst_n), .disc_i(disc_i), .trig_i(trig_i), .lat_cfg_i(lat_cfg_i),
    .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o), .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i), .word_addr_o(word_addr_o), .word_tot_o(word_tot_o)
  );

  // lat, pulse mask, pulse width, trigger cycle (255 none), expected word mask, expected ToT
  typedef struct packed {
    logic [7:0] lat; logic [3:0] m; logic [7:0] w; logic [7:0] tc; logic [3:0] em; logic [3:0] et;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'd20, 4'b0001, 8'd1,  8'd21,  4'b0001, 4'd1},
    '{8'd20, 4'b0110, 8'd3,  8'd21,  4'b0110, 4'd3},
    '{8'd20, 4'b1111, 8'd14, 8'd21,  4'b1111, 4'd14},
    '{8'd20, 4'b1000, 8'd15, 8'd21,  4'b1000, 4'd15},
    '{8'd20, 4'b0101, 8'd18, 8'd21,  4'b0101, 4'd15},
    '{8'd20, 4'b0011, 8'd30, 8'd21,  4'b0011, 4'd15},
    '{8'd20, 4'b0010, 8'd4,  8'd20,  4'b0000, 4'd0},
    '{8'd20, 4'b0100, 8'd4,  8'd22,  4'b0000, 4'd0},
    '{8'd20, 4'b1001, 8'd4,  8'd255, 4'b0000, 4'd0},
    '{8'd3,  4'b0001, 8'd4,  8'd4,   4'b0001, 4'd4},
    '{8'd3,  4'b0001, 8'd5,  8'd4,   4'b0001, 4'd15},
    '{8'd0,  4'b0100, 8'd1,  8'd1,   4'b0100, 4'd1},
    '{8'd0,  4'b0100, 8'd2,  8'd1,   4'b0100, 4'd15}
  };

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Drive one event; collect words with ready high; compare to expectation.
  task automatic run_evt(input vec_t v);
    logic [3:0] rem = v.em;
    int lo;
    lat_cfg_i = v.lat;
    for (int c = 0; c < int'(v.lat) + int'(v.w) + 8; c++) begin
      @(negedge clk);
      if (word_valid_o) begin
        if (rem == 4'b0) chk("R2 unexpected word", 1, 0);
        else begin
          lo = 0;
          for (int b = 3; b >= 0; b--) if (rem[b]) lo = b;
          chk("R5 address order", int'(word_addr_o), lo);
          chk(v.et == 4'd15 ? "R4 saturated tot" : "R3 tot", int'(word_tot_o), int'(v.et));
          rem[lo] = 1'b0;
        end
      end
      disc_i = (c < int'(v.w)) ? v.m : 4'b0;
      trig_i = (c == int'(v.tc));
    end
    trig_i = 1'b0;
    chk("R5 missing words", int'(rem), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int nw;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", int'(word_valid_o), 0);
    chk("R8 reset ovf", int'(ovf_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5: table of events
    for (int i = 0; i < NV; i++) run_evt(VECS[i]);

    // R9: overlapping events, trigger only the later window
    lat_cfg_i = 8'd10; nw = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (word_valid_o) begin
        nw++;
        chk("R9 addr", int'(word_addr_o), 2);
        chk("R9 tot", int'(word_tot_o), 4);
      end
      disc_i[0] = (c < 2);
      disc_i[2] = (c >= 3 && c < 7);
      trig_i = (c == 14);
    end
    chk("R9 word count", nw, 1);

    // R7: six events, five slots; sixth is dropped and sets overflow
    lat_cfg_i = 8'd20; nw = 0;
    for (int c = 0; c < 46; c++) begin
      @(negedge clk);
      if (word_valid_o) nw++;
      if (c == 10) chk("R7 ovf before drop", int'(ovf_o), 0);
      if (c == 12) chk("R7 ovf after drop", int'(ovf_o), 1);
      disc_i = {3'b0, (c <= 10 && c % 2 == 0)};
      trig_i = (c == 31);
    end
    chk("R7 dropped event word count", nw, 0);
    chk("R7 ovf sticky", int'(ovf_o), 1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    chk("R7 ovf cleared", int'(ovf_o), 0);
    run_evt('{8'd20, 4'b0001, 8'd2, 8'd21, 4'b0001, 4'd2});

    // R6: back-pressure holds the word
    lat_cfg_i = 8'd4; word_ready_i = 1'b0;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      disc_i = (c < 2) ? 4'b1010 : 4'b0;
      trig_i = (c == 5);
    end
    trig_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 hold valid", int'(word_valid_o), 1);
      chk("R6 hold addr", int'(word_addr_o), 1);
      chk("R6 hold tot", int'(word_tot_o), 2);
    end
    word_ready_i = 1'b1;
    @(negedge clk);
    chk("R6 second word addr", int'(word_addr_o), 3);
    chk("R6 second word valid", int'(word_valid_o), 1);
    @(negedge clk);
    chk("R6 drained", int'(word_valid_o), 0);

    // R8: reset while a word is pending
    lat_cfg_i = 8'd2; word_ready_i = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      disc_i = (c < 1) ? 4'b0100 : 4'b0;
      trig_i = (c == 3);
    end
    trig_i = 1'b0;
    @(negedge clk);
    chk("R8 pending before reset", int'(word_valid_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset drops word", int'(word_valid_o), 0);
    rst_n = 1'b1; word_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 word stays gone", int'(word_valid_o), 0);

    finish_run();
  end
endmodule